// File: doc/BRIEF.md
# Byte-Serial Multi-Cycle RV32 Integer Core

This block is a compact 32-bit integer processor core. It executes a fixed set of nine base-ISA instructions: add, sub, addi, lui, lw, sw, blt, jal and jalr. It reaches memory through one port that moves a single byte per cycle. The same port serves instruction fetch and data loads and stores. Every instruction is gathered as four bytes in little-endian order, decoded, and then executed. Loads and stores then take four more byte transfers, and the instruction ends in a write-back step. No pipelining takes place, so exactly one instruction is in flight at any time.

A 32-entry register file holds the architectural state. Register x0 always reads as zero. A separate debug read port lets a host or a testbench inspect any register at any time without disturbing execution. Any opcode outside the supported set stops the core for good: it raises a sticky halt flag and leaves the memory port idle until the next reset. The assembler idioms mv (addi with a zero immediate) and ret (jalr with x0 as destination) run without any special handling.

Top module: `bsc_core`

## Requirements
- R1: While rst_n is low, and afterwards until the first write-back, every register reads zero and halted is 0. The first cycle after reset is released reads address RESET_PC (default 0).
- R2: An instruction is fetched from addresses pc, pc+1, pc+2 and pc+3 in four consecutive cycles, with mem_rd high in each. The byte from the lowest address becomes instruction bits [7:0] and the byte from the highest becomes bits [31:24].
- R3: An instruction without memory access takes 7 cycles: 4 fetch cycles, decode, execute and write-back. lw and sw take 11 cycles. The port is idle in the decode, execute and write-back cycles. The next fetch starts at pc+4 unless a branch or jump is taken.
- R4: Opcode 0110011 adds rs1 and rs2 into rd. When instruction bit 30 (funct7 bit 5) is 1 it subtracts rs2 from rs1 instead. The register fields are rd [11:7], rs1 [19:15] and rs2 [24:20].
- R5: Opcode 0010011 writes rs1 plus a sign-extended 12-bit immediate from bits [31:20] into rd. An immediate field of 0xFF0 adds -16.
- R6: Opcode 0110111 writes bits [31:12] of the instruction into rd[31:12] and clears rd[11:0]. An upper field of 0x21 followed by an addi of -192 gives 0x20F40.
- R7: Opcode 0000011 (lw) and opcode 0100011 (sw) use the address rs1 plus an offset. For lw the offset is the sign-extended immediate in bits [31:20]. For sw the offset takes offset[11:5] from bits [31:25] and offset[4:0] from bits [11:7]. The four data bytes move in little-endian order at address, address+1, address+2 and address+3. A store drives mem_wr and never mem_rd on these cycles, and a load does the reverse.
- R8: Opcode 1100011 compares rs1 and rs2 as signed values. If rs1 < rs2, the next pc is pc plus a 13-bit offset built as follows: bit 31 gives offset[12], bit 7 gives [11], bits [30:25] give [10:5], bits [11:8] give [4:1], and [0] is 0. Otherwise the next pc is pc+4.
- R9: Opcode 1101111 writes pc+4 into rd and jumps to pc plus a sign-extended 21-bit offset built as follows: bit 31 gives offset[20], bits [19:12] give [19:12], bit 20 gives [11], bits [30:21] give [10:1], and [0] is 0.
- R10: Opcode 1100111 jumps to rs1 plus the 12-bit immediate from bits [31:20], with bit 0 of the target cleared. It writes pc+4 into rd. The target uses the value rs1 held before that write, even when rd equals rs1.
- R11: Register x0 reads as zero on every port. Writes to x0 are discarded.
- R12: An opcode outside the eight listed above sets halted one cycle after decode. halted then stays set, and mem_rd and mem_wr stay low until reset.
- R13: dbg_data shows the current contents of register dbg_sel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | XLEN | Byte address for the current transfer |
| mem_rd | output | 1 | A byte is read this cycle (fetch or load) |
| mem_wr | output | 1 | mem_wdata is written at mem_addr on this edge |
| mem_wdata | output | 8 | Store byte |
| mem_rdata | input | 8 | Byte returned combinationally for mem_addr |
| halted | output | 1 | Sticky stop after an unsupported opcode |
| dbg_sel | input | log2(NREGS) | Register selected for the debug read |
| dbg_data | output | XLEN | Contents of the selected register |

## Verification
The case where two functions meet in one cycle is a jalr whose destination equals its source register. The link write and the jump target both involve the same register, and the target must come from the old value. The program runs a jalr with rd = rs1 = x6 after loading x6 with a known target. The next fetch address must equal that old value, and x6 must then read the jalr address plus 4. Every fetch, load and store byte, the idle cycles and each destination register are compared against a behavioural instruction-level model that runs in lockstep.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   localparam int ILEN = 32;

   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;

   typedef enum logic [3:0] {
      ST_F0, ST_F1, ST_F2, ST_F3,
      ST_DEC, ST_EXE,
      ST_M0, ST_M1, ST_M2, ST_M3,
      ST_WB, ST_HALT
   } bsc_state_e;

   typedef enum logic [3:0] {
      K_ADD, K_SUB, K_ADDI, K_LUI, K_LW, K_SW, K_BLT, K_JAL, K_JALR, K_BAD
   } bsc_kind_e;

   typedef enum logic [2:0] {F_R, F_I, F_S, F_B, F_U, F_J} bsc_fmt_e;

   typedef struct packed {
      bsc_kind_e kind;
      logic      wr_rd;
      logic      mem;
   } bsc_dec_t;

endpackage

// File: rtl/bsc_regfile.sv
module bsc_regfile #(
   parameter int XLEN  = 32,
   parameter int NREGS = 32,
   parameter int NRD   = 3,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            waddr,
   input  logic [XLEN-1:0]          wdata,
   input  logic [NRD-1:0][AW-1:0]   raddr,
   output logic [NRD-1:0][XLEN-1:0] rdata
);

   if ((1 << AW) != NREGS) begin : g_bad_depth
      $error("bsc_regfile: NREGS must be a power of two");
   end

   logic [XLEN-1:0] store [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) store[i] <= '0;
      end else if (we && (waddr != '0)) begin
         store[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = (raddr[p] == '0) ? '0 : store[raddr[p]];
   end

endmodule

// File: rtl/bsc_decode.sv
module bsc_decode
   import bsc_pkg::*;
(
   input  logic [6:0] opc,
   input  logic       alt,
   output bsc_dec_t   dec,
   output bsc_fmt_e   fmt
);

   always_comb begin
      dec = '{kind: K_BAD, wr_rd: 1'b0, mem: 1'b0};
      fmt = F_R;
      case (opc)
         OPC_OP: begin
            dec.kind  = alt ? K_SUB : K_ADD;
            dec.wr_rd = 1'b1;
            fmt       = F_R;
         end
         OPC_OPIMM: begin
            dec.kind  = K_ADDI;
            dec.wr_rd = 1'b1;
            fmt       = F_I;
         end
         OPC_LUI: begin
            dec.kind  = K_LUI;
            dec.wr_rd = 1'b1;
            fmt       = F_U;
         end
         OPC_LOAD: begin
            dec.kind  = K_LW;
            dec.wr_rd = 1'b1;
            dec.mem   = 1'b1;
            fmt       = F_I;
         end
         OPC_STORE: begin
            dec.kind = K_SW;
            dec.mem  = 1'b1;
            fmt      = F_S;
         end
         OPC_BRANCH: begin
            dec.kind = K_BLT;
            fmt      = F_B;
         end
         OPC_JAL: begin
            dec.kind  = K_JAL;
            dec.wr_rd = 1'b1;
            fmt       = F_J;
         end
         OPC_JALR: begin
            dec.kind  = K_JALR;
            dec.wr_rd = 1'b1;
            fmt       = F_I;
         end
         default: begin
            dec.kind = K_BAD;
         end
      endcase
   end

endmodule

// File: rtl/bsc_immgen.sv
module bsc_immgen
   import bsc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:7]     ir,
   input  bsc_fmt_e        fmt,
   output logic [XLEN-1:0] imm
);

   if (XLEN < 32) begin : g_bad_xlen
      $error("bsc_immgen: XLEN must be at least 32");
   end

   always_comb begin
      case (fmt)
         F_I: imm = {{(XLEN-12){ir[31]}}, ir[31:20]};
         F_S: imm = {{(XLEN-12){ir[31]}}, ir[31:25], ir[11:7]};
         F_B: imm = {{(XLEN-13){ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
         F_U: imm = {{(XLEN-32){ir[31]}}, ir[31:12], 12'b0};
         F_J: imm = {{(XLEN-21){ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
         default: imm = '0;
      endcase
   end

endmodule

// File: rtl/bsc_alu.sv
module bsc_alu #(
   parameter int XLEN       = 32,
   parameter bit SHARED_CMP = 1'b1
) (
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic            sub,
   output logic [XLEN-1:0] sum,
   output logic            lt
);

   logic [XLEN-1:0] b_eff;

   assign b_eff = sub ? ~op_b : op_b;
   assign sum   = op_a + b_eff + XLEN'(sub);

   if (SHARED_CMP) begin : g_cmp_shared
      // Signed less-than taken from the difference; valid while sub is high.
      assign lt = (op_a[XLEN-1] ^ op_b[XLEN-1]) ? op_a[XLEN-1] : sum[XLEN-1];
   end else begin : g_cmp_sep
      assign lt = $signed(op_a) < $signed(op_b);
   end

endmodule

// File: rtl/bsc_core.sv
module bsc_core
   import bsc_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              NREGS      = 32,
   parameter logic [XLEN-1:0] RESET_PC   = '0,
   parameter bit              SHARED_CMP = 1'b1,
   localparam int             RIDX       = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [7:0]      mem_wdata,
   input  logic [7:0]      mem_rdata,
   output logic            halted,
   input  logic [RIDX-1:0] dbg_sel,
   output logic [XLEN-1:0] dbg_data
);

   localparam int              BYTES = ILEN / 8;
   localparam logic [XLEN-1:0] STEP  = XLEN'(BYTES);

   if (XLEN != 32) begin : g_bad_xlen
      $error("bsc_core: only XLEN = 32 is supported");
   end
   if (NREGS != 32) begin : g_bad_nregs
      $error("bsc_core: register file must hold 32 entries");
   end

   bsc_state_e      state;
   logic [XLEN-1:0] pc;
   logic [ILEN-1:0] ir;
   bsc_dec_t        dec, dec_q;
   bsc_fmt_e        fmt;
   logic [XLEN-1:0] imm, imm_q;
   logic [XLEN-1:0] a_q, b_q;
   logic [XLEN-1:0] res_q, npc_q, addr_q;

   logic [1:0]                byte_idx;
   logic                      in_fetch, in_mem;
   logic [2:0][RIDX-1:0]      rf_ra;
   logic [2:0][XLEN-1:0]      rf_rd;
   logic                      rf_we;
   logic [XLEN-1:0]           alu_b, alu_sum;
   logic                      alu_sub, alu_lt;
   logic [XLEN-1:0]           pc_rel, pc_inc;
   logic [XLEN-1:0]           exe_res, exe_npc;

   // ---------------- decode and operand sources ----------------
   bsc_decode u_dec (
      .opc (ir[6:0]),
      .alt (ir[30]),
      .dec (dec),
      .fmt (fmt)
   );

   bsc_immgen #(.XLEN(XLEN)) u_imm (
      .ir  (ir[31:7]),
      .fmt (fmt),
      .imm (imm)
   );

   assign rf_ra[0] = ir[19:15];
   assign rf_ra[1] = ir[24:20];
   assign rf_ra[2] = dbg_sel;
   assign rf_we    = (state == ST_WB) && dec_q.wr_rd;

   bsc_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(3)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .waddr (ir[11:7]),
      .wdata (res_q),
      .raddr (rf_ra),
      .rdata (rf_rd)
   );

   assign dbg_data = rf_rd[2];

   // ---------------- execute datapath ----------------
   always_comb begin
      alu_sub = (dec_q.kind == K_SUB) || (dec_q.kind == K_BLT);
      alu_b   = (dec_q.kind inside {K_ADD, K_SUB, K_BLT}) ? b_q : imm_q;
   end

   bsc_alu #(.XLEN(XLEN), .SHARED_CMP(SHARED_CMP)) u_alu (
      .op_a (a_q),
      .op_b (alu_b),
      .sub  (alu_sub),
      .sum  (alu_sum),
      .lt   (alu_lt)
   );

   assign pc_rel = pc + imm_q;
   assign pc_inc = pc + STEP;

   always_comb begin
      case (dec_q.kind)
         K_LUI:         exe_res = imm_q;
         K_JAL, K_JALR: exe_res = pc_inc;
         default:       exe_res = alu_sum;
      endcase
      case (dec_q.kind)
         K_BLT:   exe_npc = alu_lt ? pc_rel : pc_inc;
         K_JAL:   exe_npc = pc_rel;
         K_JALR:  exe_npc = {alu_sum[XLEN-1:1], 1'b0};
         default: exe_npc = pc_inc;
      endcase
   end

   // ---------------- byte port ----------------
   always_comb begin
      case (state)
         ST_F1, ST_M1: byte_idx = 2'd1;
         ST_F2, ST_M2: byte_idx = 2'd2;
         ST_F3, ST_M3: byte_idx = 2'd3;
         default:      byte_idx = 2'd0;
      endcase
   end

   assign in_fetch  = state inside {ST_F0, ST_F1, ST_F2, ST_F3};
   assign in_mem    = state inside {ST_M0, ST_M1, ST_M2, ST_M3};
   assign mem_rd    = in_fetch || (in_mem && (dec_q.kind == K_LW));
   assign mem_wr    = in_mem && (dec_q.kind == K_SW);
   assign mem_addr  = (in_mem ? addr_q : pc) + XLEN'(byte_idx);
   assign mem_wdata = b_q[{byte_idx, 3'b000} +: 8];
   assign halted    = (state == ST_HALT);

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_F0;
         pc     <= RESET_PC;
         ir     <= '0;
         dec_q  <= '0;
         imm_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
         res_q  <= '0;
         npc_q  <= '0;
         addr_q <= '0;
      end else begin
         case (state)
            ST_F0: begin ir[{byte_idx, 3'b000} +: 8] <= mem_rdata; state <= ST_F1; end
            ST_F1: begin ir[{byte_idx, 3'b000} +: 8] <= mem_rdata; state <= ST_F2; end
            ST_F2: begin ir[{byte_idx, 3'b000} +: 8] <= mem_rdata; state <= ST_F3; end
            ST_F3: begin ir[{byte_idx, 3'b000} +: 8] <= mem_rdata; state <= ST_DEC; end
            ST_DEC: begin
               dec_q <= dec;
               imm_q <= imm;
               a_q   <= rf_rd[0];
               b_q   <= rf_rd[1];
               state <= (dec.kind == K_BAD) ? ST_HALT : ST_EXE;
            end
            ST_EXE: begin
               res_q  <= exe_res;
               npc_q  <= exe_npc;
               addr_q <= alu_sum;
               state  <= dec_q.mem ? ST_M0 : ST_WB;
            end
            ST_M0, ST_M1, ST_M2, ST_M3: begin
               if (dec_q.kind == K_LW) res_q[{byte_idx, 3'b000} +: 8] <= mem_rdata;
               case (state)
                  ST_M0:   state <= ST_M1;
                  ST_M1:   state <= ST_M2;
                  ST_M2:   state <= ST_M3;
                  default: state <= ST_WB;
               endcase
            end
            ST_WB: begin
               pc    <= npc_q;
               state <= ST_F0;
            end
            default: state <= ST_HALT;
         endcase
      end
   end

endmodule

// File: rtl/bsc_core_chk.sv
module bsc_core_chk
   import bsc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int RIDX = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] mem_addr,
   input logic            mem_rd,
   input logic            mem_wr,
   input logic            halted,
   input logic [RIDX-1:0] dbg_sel,
   input logic [XLEN-1:0] dbg_data,
   input bsc_state_e      state
);

   AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state inside {ST_F1, ST_F2, ST_F3}) |-> (mem_rd && mem_addr == $past(mem_addr) + XLEN'(1))); // R2

   AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WB) |=> (mem_rd && !mem_wr && !halted)); // R3

   AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R7

   AST_STORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + XLEN'(1))); // R7

   AST_X0_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_sel == '0) |-> (dbg_data == '0)); // R11

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R12

   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_rd && !mem_wr)); // R12

endmodule

bind bsc_core bsc_core_chk #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .halted   (halted),
   .dbg_sel  (dbg_sel),
   .dbg_data (dbg_data),
   .state    (state)
);

// File: tb/bsc_core_tb_top.sv
module bsc_core_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        halted;
   logic [4:0]  dbg_sel;
   logic [31:0] dbg_data;

   always #5 clk = ~clk;

   bsc_core dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .halted    (halted),
      .dbg_sel   (dbg_sel),
      .dbg_data  (dbg_data)
   );

   // memory seen by the core, and the model's own copy
   logic [7:0]  dmem [256];
   logic [7:0]  mmem [256];
   logic [31:0] mreg [32];
   logic [31:0] mpc;

   assign mem_rdata = dmem[mem_addr[7:0]];
   always @(posedge clk) if (mem_wr) dmem[mem_addr[7:0]] <= mem_wdata;

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] e_r(input logic alt, input int rs2, input int rs1, input int rd);
      return {1'b0, alt, 5'b0, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
   endfunction
   function automatic logic [31:0] e_i(input int imm, input int rs1, input logic [2:0] f3,
                                       input int rd, input logic [6:0] op);
      logic [31:0] t = imm;
      return {t[11:0], 5'(rs1), f3, 5'(rd), op};
   endfunction
   function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1);
      logic [31:0] t = imm;
      return {t[11:5], 5'(rs2), 5'(rs1), 3'b010, t[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] e_b(input int imm, input int rs1, input int rs2);
      logic [31:0] t = imm;
      return {t[12], t[10:5], 5'(rs2), 5'(rs1), 3'b100, t[4:1], t[11], 7'b1100011};
   endfunction
   function automatic logic [31:0] e_u(input int imm20, input int rd);
      logic [31:0] t = imm20;
      return {t[19:0], 5'(rd), 7'b0110111};
   endfunction
   function automatic logic [31:0] e_j(input int imm, input int rd);
      logic [31:0] t = imm;
      return {t[20], t[10:1], t[11], t[19:12], 5'(rd), 7'b1101111};
   endfunction

   task automatic put(input int addr, input logic [31:0] w);
      for (int k = 0; k < 4; k++) begin
         dmem[addr + k] = w[8*k +: 8];
         mmem[addr + k] = w[8*k +: 8];
      end
   endtask

   // Runs the program in lockstep with a behavioural instruction model.
   task automatic run_program();
      logic [31:0] w, rs1v, rs2v, ii, si, bi, ji, ea, nv, npc;
      logic [6:0]  opc;
      logic [4:0]  rd;
      logic        legal, is_ld, is_st, wr;
      string       flow_tag, wtag;
      bit          done;
      done     = 0;
      flow_tag = "R1";
      for (int guard = 0; guard < 400 && !done; guard++) begin
         w    = {mmem[8'(mpc + 3)], mmem[8'(mpc + 2)], mmem[8'(mpc + 1)], mmem[mpc[7:0]]};
         opc  = w[6:0];
         rd   = w[11:7];
         rs1v = mreg[w[19:15]];
         rs2v = mreg[w[24:20]];
         ii   = {{20{w[31]}}, w[31:20]};
         si   = {{20{w[31]}}, w[31:25], w[11:7]};
         bi   = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
         ji   = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
         legal = opc inside {7'b0110011, 7'b0010011, 7'b0110111, 7'b0000011,
                             7'b0100011, 7'b1100011, 7'b1101111, 7'b1100111};
         is_ld = (opc == 7'b0000011);
         is_st = (opc == 7'b0100011);
         ea    = rs1v + (is_st ? si : ii);

         // fetch cycles (R2); first byte address carries the previous flow decision
         for (int c = 0; c < 4; c++) begin
            chk((c == 0) ? flow_tag : "R2", {halted, mem_rd, mem_wr, mem_addr},
                {1'b0, 1'b1, 1'b0, mpc + 32'(c)});
            tick();
         end
         chk("R3 decode idle", {halted, mem_rd, mem_wr}, 3'b000);
         tick();
         if (!legal) begin
            chk("R12 halt raised", halted, 1'b1);
            for (int c = 0; c < 20; c++) begin
               chk("R12 halt quiet", {halted, mem_rd, mem_wr}, 3'b100);
               tick();
            end
            done = 1;
         end else begin
            chk("R3 execute idle", {halted, mem_rd, mem_wr}, 3'b000);
            tick();
            if (is_ld || is_st) begin
               for (int c = 0; c < 4; c++) begin
                  chk("R7 data byte", {halted, mem_rd, mem_wr, mem_addr},
                      {1'b0, is_ld, is_st, ea + 32'(c)});
                  if (is_st) chk("R7 store data", mem_wdata, rs2v[8*c +: 8]);
                  tick();
               end
            end
            chk("R3 writeback idle", {halted, mem_rd, mem_wr}, 3'b000);
            tick();

            // architectural effect in the model
            wr = 1'b1;
            nv = 32'h0;
            npc = mpc + 32'd4;
            flow_tag = "R3";
            wtag = "R4";
            case (opc)
               7'b0110011: begin nv = w[30] ? rs1v - rs2v : rs1v + rs2v; wtag = "R4"; end
               7'b0010011: begin nv = rs1v + ii; wtag = "R5"; end
               7'b0110111: begin nv = {w[31:12], 12'h000}; wtag = "R6"; end
               7'b0000011: begin
                  nv = {mmem[8'(ea + 3)], mmem[8'(ea + 2)], mmem[8'(ea + 1)], mmem[ea[7:0]]};
                  wtag = "R7";
               end
               7'b0100011: begin
                  wr = 1'b0;
                  for (int k = 0; k < 4; k++) mmem[8'(ea + 32'(k))] = rs2v[8*k +: 8];
               end
               7'b1100011: begin
                  wr = 1'b0;
                  if ($signed(rs1v) < $signed(rs2v)) npc = mpc + bi;
                  flow_tag = "R8";
               end
               7'b1101111: begin nv = mpc + 32'd4; npc = mpc + ji; wtag = "R9"; flow_tag = "R9"; end
               default: begin
                  nv = mpc + 32'd4;
                  npc = (rs1v + ii) & 32'hFFFF_FFFE;
                  wtag = "R10";
                  flow_tag = "R10";
               end
            endcase
            if (wr && rd != 5'd0) mreg[rd] = nv;
            mpc = npc;
            if (wr) begin
               dbg_sel = rd;
               #1;
               chk((rd == 5'd0) ? "R11 x0 write dropped" : wtag, dbg_data, mreg[rd]);
            end
         end
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 50000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int mism;
      rst_n   = 1'b0;
      dbg_sel = 5'd0;
      for (int i = 0; i < 256; i++) begin dmem[i] = 8'h00; mmem[i] = 8'h00; end
      for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
      mpc = 32'h0;

      put(0,   e_u(32'h21, 10));                    // lui  x10,0x21
      put(4,   e_i(-192, 10, 3'b000, 10, 7'b0010011)); // addi x10,x10,-192
      put(8,   e_i(256, 0, 3'b000, 2, 7'b0010011));   // x2 = 256
      put(12,  32'hFF010113);                        // addi x2,x2,0xFF0 (-16)
      put(16,  e_i(2, 0, 3'b000, 11, 7'b0010011));
      put(20,  e_i(1, 0, 3'b000, 12, 7'b0010011));
      put(24,  e_r(1'b0, 12, 11, 13));                // add  x13 = 3
      put(28,  e_r(1'b1, 11, 12, 14));                // sub  x14 = -1
      put(32,  e_s(8, 10, 2));                        // sw x10,8(x2)
      put(36,  e_i(8, 2, 3'b010, 15, 7'b0000011));    // lw x15,8(x2)
      put(40,  e_s(-4, 14, 2));                       // sw x14,-4(x2)
      put(44,  e_i(-4, 2, 3'b010, 16, 7'b0000011));   // lw x16,-4(x2)
      put(48,  e_b(8, 14, 11));                       // blt x14,x11 taken
      put(52,  e_i(99, 0, 3'b000, 17, 7'b0010011));   // skipped
      put(56,  e_b(8, 11, 14));                       // blt x11,x14 not taken
      put(60,  e_i(7, 0, 3'b000, 18, 7'b0010011));
      put(64,  e_j(12, 1));                           // jal x1,+12
      put(68,  e_i(5, 0, 3'b000, 19, 7'b0010011));
      put(72,  e_j(24, 0));                           // jal x0,+24
      put(76,  e_i(9, 0, 3'b000, 20, 7'b0010011));
      put(80,  e_i(1, 1, 3'b000, 0, 7'b1100111));     // jalr x0,1(x1): bit 0 cleared
      put(96,  e_i(3, 0, 3'b000, 22, 7'b0010011));
      put(100, e_i(-1, 22, 3'b000, 22, 7'b0010011));
      put(104, e_b(-4, 0, 22));                       // backward loop
      put(108, e_i(5, 0, 3'b000, 0, 7'b0010011));     // write to x0
      put(112, e_i(124, 0, 3'b000, 6, 7'b0010011));
      put(116, e_i(0, 6, 3'b000, 6, 7'b1100111));     // jalr x6,0(x6)
      put(120, e_i(1, 0, 3'b000, 23, 7'b0010011));    // skipped
      put(124, e_r(1'b0, 0, 13, 21));                 // add x21,x13,x0
      put(128, 32'hFFFF_FFFF);                        // unsupported opcode

      repeat (3) @(negedge clk);
      chk("R1 reset halted", {halted, mem_wr}, 2'b00);
      dbg_sel = 5'd10;
      #1 chk("R1 reset reg", dbg_data, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      run_program();

      for (int r = 0; r < 32; r++) begin
         dbg_sel = 5'(r);
         #1 chk((r == 0) ? "R11 x0 read" : "R13 debug read", dbg_data, mreg[r]);
      end
      mism = 0;
      for (int i = 0; i < 256; i++) if (dmem[i] !== mmem[i]) mism++;
      chk("R7 memory image", mism, 0);

      // second reset clears state and restarts fetch
      @(negedge clk);
      rst_n = 1'b0;
      dbg_sel = 5'd13;
      #1 chk("R1 reset clears regs", dbg_data, 32'h0);
      chk("R1 reset clears halt", halted, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      #1 chk("R1 restart fetch", {halted, mem_rd, mem_wr, mem_addr}, {3'b010, 32'h0});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule